// File: doc/BRIEF.md
# MIDI Serial Port with Host Byte Window

This block is a host-facing MIDI port that behaves like a classic UART-mode MIDI interface sitting behind a two-address byte window. A receiver deserializes bytes arriving on the serial input pin at 31250 bit/s and queues them in a receive FIFO. The host drains that queue through the data address. A byte the host writes to the data address is sent on the serial output pin at the same rate.

The second address has different meanings for reads and writes. A read returns a status byte. A write is taken as a command. Two command codes place an acknowledge byte (0xFE) in the receive queue, which is how host software confirms that the port is present. The bit timing is derived from the system clock inside the block. The receiver samples each bit 16 times and takes the bit value from the middle sample.

Top module: `midi_host_port`

## Requirements
- R1: Every transmitted bit lasts exactly CLK_HZ/BAUD clock cycles. The receiver samples at 16 ticks per bit and takes each bit value at the eighth tick.
- R2: The transmitter idles high. Each frame is one low start bit, then eight data bits with the least significant bit first, then one high stop bit. The frame starts in the cycle after the data write.
- R3: A correctly framed received byte is pushed into the receive FIFO. Each data-address read (address 0) returns the oldest queued byte, one cycle after the read strobe, and removes that byte.
- R4: A received frame whose stop bit samples low is discarded. After such a frame the receiver waits for the line to return high before it looks for a new start bit.
- R5: A status read (address 1) returns bit 7 = 1 when the receive FIFO is empty and bit 6 = 1 while the transmitter is busy. Bit 5 is the overflow flag. Bits 4..0 read 0.
- R6: A data write while the transmitter is busy is ignored. The frame in progress is unaffected and no extra frame follows.
- R7: When the FIFO already holds FIFO_DEPTH bytes, a newly received byte is dropped and status bit 5 is set. The bytes already queued are kept unchanged.
- R8: Command 0xFF empties the FIFO, clears the overflow flag and queues the byte 0xFE.
- R9: Command 0x3F queues 0xFE. Any other command code leaves the FIFO and status unchanged.
- R10: A data-address read while the FIFO is empty returns 0x00 and leaves the FIFO empty.
- R11: A low pulse on the receive line that is shorter than half a bit is not taken as a start bit, so no byte is queued.
- R12: After reset, the serial output is high, the status byte is 0x80 and the read data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Selects the port for the current access |
| bus_addr | input | 1 | 0 = data, 1 = status (read) / command (write) |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data or command code |
| bus_rdata | output | 8 | Registered read data, valid the cycle after the read strobe |
| midi_rx | input | 1 | Serial MIDI input |
| midi_tx | output | 1 | Serial MIDI output |

## Verification
The bench builds the port with CLK_HZ = 2 MHz and FIFO_DEPTH = 8. With these values a bit is 64 clocks and an oversample tick is 4 clocks, so the serial timing checks are exact, each frame is short, and a 48-value receive sweep and a 16-value transmit sweep fit the run easily. The depth of 8 means ten received bytes are enough to reach the full-queue drop and the overflow flag. The same test then checks that the surviving bytes are intact and that command 0xFF clears the flag.

// File: rtl/midi_port_pkg.sv
package midi_port_pkg;
  localparam int OVERSAMPLE = 16;

  localparam int ST_RX_EMPTY = 7;
  localparam int ST_TX_BUSY  = 6;
  localparam int ST_OVF      = 5;

  localparam logic [7:0] CMD_PORT_RESET = 8'hFF;
  localparam logic [7:0] CMD_UART_MODE  = 8'h3F;
  localparam logic [7:0] ACK_BYTE       = 8'hFE;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD
  } rx_state_t;
endpackage

// File: rtl/mpu_os_tick.sv
module mpu_os_tick #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/mpu_uart_rx.sv
module mpu_uart_rx
  import midi_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rx_in,
  output logic       valid,
  output logic [7:0] data
);
  localparam logic [3:0] MID_TICK  = 4'(OVERSAMPLE / 2 - 1);
  localparam logic [3:0] LAST_TICK = 4'(OVERSAMPLE - 1);

  rx_state_t  state;
  logic       rx_s1, rx_s2;
  logic [3:0] os_cnt;
  logic [2:0] bit_cnt;
  logic [7:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
    end else begin
      rx_s1 <= rx_in;
      rx_s2 <= rx_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      os_cnt  <= '0;
      bit_cnt <= '0;
      shreg   <= '0;
      valid   <= 1'b0;
      data    <= '0;
    end else begin
      valid <= 1'b0;
      case (state)
        RX_IDLE: if (!rx_s2) begin
          state  <= RX_START;
          os_cnt <= '0;
        end
        RX_START: if (tick) begin
          if (os_cnt == MID_TICK) begin
            os_cnt  <= '0;
            bit_cnt <= '0;
            state   <= rx_s2 ? RX_IDLE : RX_DATA;
          end else os_cnt <= os_cnt + 1'b1;
        end
        RX_DATA: if (tick) begin
          if (os_cnt == LAST_TICK) begin
            os_cnt <= '0;
            shreg  <= {rx_s2, shreg[7:1]};
            if (bit_cnt == 3'd7) state <= RX_STOP;
            else bit_cnt <= bit_cnt + 1'b1;
          end else os_cnt <= os_cnt + 1'b1;
        end
        RX_STOP: if (tick) begin
          if (os_cnt == LAST_TICK) begin
            os_cnt <= '0;
            if (rx_s2) begin
              valid <= 1'b1;
              data  <= shreg;
              state <= RX_IDLE;
            end else state <= RX_HOLD;
          end else os_cnt <= os_cnt + 1'b1;
        end
        RX_HOLD: if (rx_s2) state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R3: a received byte is handed over as a single-cycle pulse
  p_valid_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  // R4: a framing error never produces a byte in the next cycle
  p_hold_no_byte_r4: assert property (@(posedge clk) disable iff (rst)
    (state == RX_HOLD) |=> !valid);
endmodule

// File: rtl/mpu_uart_tx.sv
module mpu_uart_tx #(
  parameter int CLKS_PER_BIT = 1600
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] din,
  output logic       tx_line,
  output logic       busy
);
  localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;

  logic [CW-1:0] cnt;
  logic [3:0]    bit_idx;
  logic [8:0]    sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_line <= 1'b1;
      busy    <= 1'b0;
      cnt     <= '0;
      bit_idx <= '0;
      sh      <= '1;
    end else if (!busy) begin
      if (load) begin
        sh      <= {1'b1, din};
        tx_line <= 1'b0;
        busy    <= 1'b1;
        cnt     <= '0;
        bit_idx <= '0;
      end
    end else if (cnt == CW'(CLKS_PER_BIT - 1)) begin
      cnt <= '0;
      if (bit_idx == 4'd9) begin
        busy <= 1'b0;
      end else begin
        tx_line <= sh[0];
        sh      <= {1'b1, sh[8:1]};
        bit_idx <= bit_idx + 1'b1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: line is high whenever no frame is in flight
  p_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx_line);
  // R2: a load on an idle transmitter starts the frame with a low start bit
  p_start_bit_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && load) |=> (busy && !tx_line));
endmodule

// File: rtl/mpu_rx_fifo.sv
module mpu_rx_fifo #(
  parameter int DEPTH = 128,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  input  logic         flush,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          do_wr, do_rd;
  logic [AW-1:0] wr_addr;

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign do_wr   = push && (flush || !full);
  assign do_rd   = pop && !empty && !flush;
  assign wr_addr = flush ? '0 : wr_ptr;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_addr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= do_wr ? AW'(1) : '0;
      count  <= do_wr ? (AW+1)'(1) : '0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= rd_ptr + 1'b1;
      count <= count + (AW+1)'(do_wr) - (AW+1)'(do_rd);
    end
  end

  // R7: occupancy never exceeds the depth
  p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH));
  // R7: a push into a full queue without a pop leaves it full
  p_full_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> full);
endmodule

// File: rtl/midi_host_port.sv
module midi_host_port
  import midi_port_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int BAUD       = 31250,
  parameter int FIFO_DEPTH = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_sel,
  input  logic       bus_addr,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       midi_rx,
  output logic       midi_tx
);
  localparam int CLKS_PER_BIT = CLK_HZ / BAUD;
  localparam int OS_DIV = (CLKS_PER_BIT / OVERSAMPLE > 0) ? CLKS_PER_BIT / OVERSAMPLE : 1;

  logic       os_tick, rx_valid, tx_busy, ovf;
  logic [7:0] rx_data, fifo_dout, push_data;
  logic       fifo_empty, fifo_full;
  logic       rd_data, rd_stat, wr_data, wr_cmd;
  logic       cmd_ack, cmd_flush, push, pop;

  assign rd_data   = bus_sel && bus_rd && !bus_addr;
  assign rd_stat   = bus_sel && bus_rd &&  bus_addr;
  assign wr_data   = bus_sel && bus_wr && !bus_addr;
  assign wr_cmd    = bus_sel && bus_wr &&  bus_addr;
  assign cmd_flush = wr_cmd && (bus_wdata == CMD_PORT_RESET);
  assign cmd_ack   = cmd_flush || (wr_cmd && (bus_wdata == CMD_UART_MODE));
  assign push      = cmd_ack || rx_valid;
  assign push_data = cmd_ack ? ACK_BYTE : rx_data;
  assign pop       = rd_data && !fifo_empty;

  mpu_os_tick #(.DIV(OS_DIV)) tick_i (
    .clk(clk), .rst(rst), .tick(os_tick)
  );

  mpu_uart_rx rx_i (
    .clk(clk), .rst(rst), .tick(os_tick), .rx_in(midi_rx),
    .valid(rx_valid), .data(rx_data)
  );

  mpu_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) tx_i (
    .clk(clk), .rst(rst), .load(wr_data), .din(bus_wdata),
    .tx_line(midi_tx), .busy(tx_busy)
  );

  mpu_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) fifo_i (
    .clk(clk), .rst(rst), .push(push), .din(push_data), .pop(pop),
    .flush(cmd_flush), .dout(fifo_dout), .empty(fifo_empty), .full(fifo_full)
  );

  always_ff @(posedge clk) begin
    if (rst) ovf <= 1'b0;
    else if (cmd_flush) ovf <= 1'b0;
    else if (push && fifo_full) ovf <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd_data) bus_rdata <= fifo_empty ? 8'h00 : fifo_dout;
    else if (rd_stat) begin
      bus_rdata              <= '0;
      bus_rdata[ST_RX_EMPTY] <= fifo_empty;
      bus_rdata[ST_TX_BUSY]  <= tx_busy;
      bus_rdata[ST_OVF]      <= ovf;
    end
  end

  // R8: a reset command leaves exactly the acknowledge queued, no overflow
  p_reset_ack_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_flush |=> (!fifo_empty && !ovf));
  // R6: a data write while busy does not end the frame in progress
  p_busy_write_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_data && tx_busy && $past(tx_busy)) |=> tx_busy || $past(midi_tx));
endmodule

// File: tb/midi_host_port_tb.sv
module midi_host_port_tb_top;
  localparam int CLK_HZ = 2_000_000;
  localparam int BAUD   = 31250;
  localparam int DEPTH  = 8;
  localparam int BIT    = CLK_HZ / BAUD;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_addr = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       midi_rx = 1'b1;
  logic       midi_tx;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  midi_host_port #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .midi_rx(midi_rx), .midi_tx(midi_tx)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stop);
    midi_rx = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      midi_rx = b[i];
      repeat (BIT) @(negedge clk);
    end
    midi_rx = stop;
    repeat (BIT) @(negedge clk);
    midi_rx = 1'b1;
    repeat (BIT / 2) @(negedge clk);
  endtask

  task automatic get_tx(output logic [7:0] b, output logic stopv, output logic seen);
    int w = 0;
    b = '0; stopv = 1'b0; seen = 1'b0;
    @(negedge clk);
    while (midi_tx && w < 4 * BIT) begin
      @(negedge clk);
      w++;
    end
    if (!midi_tx) begin
      seen = 1'b1;
      repeat (BIT / 2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        repeat (BIT) @(negedge clk);
        b[i] = midi_tx;
      end
      repeat (BIT) @(negedge clk);
      stopv = midi_tx;
      repeat (BIT) @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d, e;
    logic sv, seen;
    int lows;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R12: reset state
    chk("R12 tx idle", int'(midi_tx), 1);
    chk("R12 rdata", int'(bus_rdata), 0);
    bus_read(1'b1, d);
    chk("R12 status", int'(d), 8'h80);

    // R3: receive sweep, each byte read back immediately
    for (int i = 0; i < 48; i++) begin
      e = 8'((i * 37 + 5) % 256);
      send_rx(e, 1'b1);
      bus_read(1'b0, d);
      chk("R3 rx sweep", int'(d), int'(e));
    end
    bus_read(1'b1, d);
    chk("R5 empty after drain", int'(d), 8'h80);

    // R3: ordering of several queued bytes
    send_rx(8'h90, 1'b1); send_rx(8'h3C, 1'b1); send_rx(8'h7F, 1'b1);
    bus_read(1'b1, d);
    chk("R5 data available", int'(d), 8'h00);
    bus_read(1'b0, d); chk("R3 order 0", int'(d), 8'h90);
    bus_read(1'b0, d); chk("R3 order 1", int'(d), 8'h3C);
    bus_read(1'b0, d); chk("R3 order 2", int'(d), 8'h7F);

    // R10: read of empty queue
    bus_read(1'b0, d);
    chk("R10 empty read", int'(d), 0);
    bus_read(1'b1, d);
    chk("R10 still empty", int'(d), 8'h80);

    // R4: bad stop bit discarded, then recovery
    send_rx(8'hA5, 1'b0);
    repeat (BIT) @(negedge clk);
    bus_read(1'b1, d);
    chk("R4 bad stop dropped", int'(d), 8'h80);
    send_rx(8'h42, 1'b1);
    bus_read(1'b0, d);
    chk("R4 recovery byte", int'(d), 8'h42);

    // R11: short glitch rejected
    midi_rx = 1'b0;
    repeat (BIT / 4) @(negedge clk);
    midi_rx = 1'b1;
    repeat (12 * BIT) @(negedge clk);
    bus_read(1'b1, d);
    chk("R11 glitch ignored", int'(d), 8'h80);

    // R1: start + eight zero data bits are low for 9 bit times
    bus_write(1'b0, 8'h00);
    lows = 0;
    while (!midi_tx && lows < 20 * BIT) begin
      @(negedge clk);
      if (!midi_tx) lows++;
    end
    chk("R1 bit length", lows + 1, 9 * BIT);
    repeat (2 * BIT) @(negedge clk);

    // R2: transmit sweep
    for (int i = 0; i < 16; i++) begin
      e = 8'((i * 53 + 7) % 256);
      bus_write(1'b0, e);
      get_tx(d, sv, seen);
      chk("R2 tx start seen", int'(seen), 1);
      chk("R2 tx data", int'(d), int'(e));
      chk("R2 tx stop", int'(sv), 1);
    end

    // R5: busy flag while sending
    bus_write(1'b0, 8'h11);
    bus_read(1'b1, d);
    chk("R5 tx busy", int'(d), 8'hC0);
    get_tx(d, sv, seen);
    bus_read(1'b1, d);
    chk("R5 tx ready", int'(d), 8'h80);

    // R6: second write during a frame is ignored
    bus_write(1'b0, 8'h5A);
    bus_write(1'b0, 8'hC3);
    get_tx(d, sv, seen);
    chk("R6 first byte kept", int'(d), 8'h5A);
    lows = 0;
    for (int i = 0; i < 2 * 10 * BIT; i++) begin
      @(negedge clk);
      if (!midi_tx) lows++;
    end
    chk("R6 no extra frame", lows, 0);

    // R7: overflow
    for (int i = 0; i < DEPTH + 2; i++) send_rx(8'(8'h30 + i), 1'b1);
    bus_read(1'b1, d);
    chk("R7 overflow status", int'(d), 8'h20);
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(1'b0, d);
      chk("R7 kept bytes", int'(d), 8'h30 + i);
    end
    bus_read(1'b1, d);
    chk("R7 sticky flag", int'(d), 8'hA0);

    // R8: reset command clears flag and queues ack
    bus_write(1'b1, 8'hFF);
    bus_read(1'b1, d);
    chk("R8 flag cleared", int'(d), 8'h00);
    bus_read(1'b0, d);
    chk("R8 ack", int'(d), 8'hFE);
    send_rx(8'h01, 1'b1); send_rx(8'h02, 1'b1); send_rx(8'h03, 1'b1);
    bus_write(1'b1, 8'hFF);
    bus_read(1'b0, d);
    chk("R8 flush then ack", int'(d), 8'hFE);
    bus_read(1'b1, d);
    chk("R8 flushed", int'(d), 8'h80);

    // R9: UART-mode command acks, other codes do nothing
    bus_write(1'b1, 8'h3F);
    bus_read(1'b0, d);
    chk("R9 uart ack", int'(d), 8'hFE);
    bus_write(1'b1, 8'h12);
    bus_read(1'b1, d);
    chk("R9 other cmd", int'(d), 8'h80);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule